// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two floating-point operands of one format, single or double precision, under a 4-bit predicate code. It produces a single condition bit for the branch logic next to it. Each operand is classified as a NaN (exponent all ones, mantissa non-zero) or a quiet NaN (a NaN with the top mantissa bit set). The predicate code decides which NaN kinds raise an invalid-operation cause.

When an invalid cause is raised, the invalid-trap enable decides what happens. With the trap disabled, the sticky invalid flag is set and the condition bit takes the new result. With the trap enabled, an exception request is issued, and both the condition bit and the sticky flag are left as they were.

A compare is launched by a one-cycle start strobe. The unit accepts one compare on every cycle and never applies back-pressure. Its results are registered, so they appear on the clock edge that samples the strobe.

Top module: `fpcmp_cond_unit`

## Requirements
- R1: Reset is active low. After reset, the condition bit, the invalid pulse, the exception request and the sticky flag all read 0.
- R2: The predicate code selects the result. Bit 0 adds "unordered". Bit 1 adds "equal". Bit 2 adds "less than". The equal and less-than terms count only when the operands are ordered, and the result is the OR of the selected terms.
- R3: Codes 0 and 8 always yield false, whatever the operands are.
- R4: An operand is a NaN when its exponent is all ones and its mantissa is non-zero. The pair is unordered when either operand is a NaN. An infinity is not a NaN.
- R5: Positive zero and negative zero compare equal. The remaining values are ordered by sign and magnitude, so that -2 < -1 < 0 < 1 < infinity.
- R6: With code bit 3 clear, invalid is raised only when an operand is a quiet NaN, meaning its top mantissa bit is set. With code bit 3 set, invalid is raised when either operand is any NaN.
- R7: With the trap disabled, a raised invalid produces a one-cycle invalid pulse and sets the sticky flag, and the condition bit takes the computed result.
- R8: With the trap enabled, a raised invalid produces the invalid pulse together with an exception request. The condition bit and the sticky flag keep their prior values.
- R9: The results appear on the clock edge that samples start. The invalid and exception pulses last one cycle, and the condition bit holds while start is low.
- R10: With the format select at 0, only bits [31:0] are used, laid out as sign 31, exponent 30:23 and mantissa 22:0, and bits [63:32] are ignored. With the format select at 1, the double layout is used: sign 63, exponent 62:52 and mantissa 51:0.
- R11: Once set, the sticky flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle compare strobe |
| dbl_i | input | 1 | Format select: 0 single, 1 double |
| opa_i | input | 64 | First operand word |
| opb_i | input | 64 | Second operand word |
| cond_i | input | 4 | Predicate code |
| trap_en_i | input | 1 | Invalid-trap enable |
| cond_flag_o | output | 1 | Condition bit for branch logic |
| invalid_o | output | 1 | One-cycle invalid-cause pulse |
| exc_req_o | output | 1 | One-cycle exception request |
| inv_sticky_o | output | 1 | Sticky invalid flag |

## Verification
The hardest case to show from the ports is a trapped invalid compare that leaves the condition bit untouched. A held value of 0 cannot be told apart from a freshly computed false. The stimulus therefore first sets the bit to 1 with an ordered less-than. It then issues a quiet-NaN compare whose computed result would be 0, with the trap enabled, and confirms that the bit and the sticky flag did not move. Signalling NaNs are also driven under the low-half codes, to show that no invalid cause is raised there while the unordered result is still reported.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int unsigned SP_EXP_W = 8;
  localparam int unsigned SP_MAN_W = 23;
  localparam int unsigned DP_EXP_W = 11;
  localparam int unsigned DP_MAN_W = 52;
  localparam int unsigned CODE_W   = 4;
  // predicate code bit positions: decoded by the predicate stage
  localparam int unsigned PB_UNORD = 0;
  localparam int unsigned PB_EQ    = 1;
  localparam int unsigned PB_LT    = 2;
  localparam int unsigned PB_SIG   = 3;

  typedef struct packed {
    logic unord;
    logic eq;
    logic lt;
  } rel_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W    = 1 + EXP_W + MAN_W,
  localparam int unsigned MAG_W = EXP_W + MAN_W
) (
  input  logic [W-1:0]     word_i,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             nan_o,
  output logic             qnan_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  always_comb begin
    sign_o = word_i[W-1];
    mag_o  = word_i[MAG_W-1:0];
    exp_f  = word_i[MAG_W-1:MAN_W];
    man_f  = word_i[MAN_W-1:0];
    nan_o  = (&exp_f) && (|man_f);
    qnan_o = nan_o && man_f[MAN_W-1];
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int unsigned MAG_W = 63
) (
  input  logic             sign_a_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output logic             eq_o,
  output logic             lt_o
);
  logic both_zero;
  logic mag_lt, mag_gt;

  always_comb begin
    both_zero = (mag_a_i == '0) && (mag_b_i == '0);
    mag_lt    = mag_a_i < mag_b_i;
    mag_gt    = mag_a_i > mag_b_i;
    eq_o      = both_zero || ((sign_a_i == sign_b_i) && (mag_a_i == mag_b_i));
    if (both_zero)
      lt_o = 1'b0;
    else if (sign_a_i != sign_b_i)
      lt_o = sign_a_i;
    else if (sign_a_i)
      lt_o = mag_gt;
    else
      lt_o = mag_lt;
  end
endmodule

// File: rtl/fpcmp_predicate.sv
module fpcmp_predicate
  import fpcmp_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  rel_t              rel_i,
  input  logic              any_nan_i,
  input  logic              any_qnan_i,
  output logic              hit_o,
  output logic              raise_o
);
  logic ordered_hit;

  always_comb begin
    ordered_hit = (code_i[PB_EQ] && rel_i.eq) || (code_i[PB_LT] && rel_i.lt);
    hit_o       = (code_i[PB_UNORD] && rel_i.unord) || (!rel_i.unord && ordered_hit);
    raise_o     = code_i[PB_SIG] ? any_nan_i : any_qnan_i;
  end
endmodule

// File: rtl/fpcmp_cond_unit.sv
module fpcmp_cond_unit
  import fpcmp_pkg::*;
#(
  parameter int unsigned S_EXP_W = SP_EXP_W,
  parameter int unsigned S_MAN_W = SP_MAN_W,
  parameter int unsigned D_EXP_W = DP_EXP_W,
  parameter int unsigned D_MAN_W = DP_MAN_W,
  localparam int unsigned WORD_W = 1 + D_EXP_W + D_MAN_W,
  localparam int unsigned S_W    = 1 + S_EXP_W + S_MAN_W,
  localparam int unsigned MAG_W  = D_EXP_W + D_MAN_W,
  localparam int unsigned S_MAG_W = S_EXP_W + S_MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dbl_i,
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] opb_i,
  input  logic [CODE_W-1:0] cond_i,
  input  logic              trap_en_i,
  output logic              cond_flag_o,
  output logic              invalid_o,
  output logic              exc_req_o,
  output logic              inv_sticky_o
);
  logic [WORD_W-1:0] opnd [2];
  logic              sgn  [2];
  logic [MAG_W-1:0]  mag  [2];
  logic              nan  [2];
  logic              qnan [2];

  assign opnd[0] = opa_i;
  assign opnd[1] = opb_i;

  for (genvar g = 0; g < 2; g++) begin : g_op
    logic               s_sgn, s_nan, s_qnan, d_sgn, d_nan, d_qnan;
    logic [S_MAG_W-1:0] s_mag;
    logic [MAG_W-1:0]   d_mag;

    fpcmp_classify #(.EXP_W(S_EXP_W), .MAN_W(S_MAN_W)) u_sp (
      .word_i(opnd[g][S_W-1:0]), .sign_o(s_sgn), .mag_o(s_mag),
      .nan_o(s_nan), .qnan_o(s_qnan));
    fpcmp_classify #(.EXP_W(D_EXP_W), .MAN_W(D_MAN_W)) u_dp (
      .word_i(opnd[g]), .sign_o(d_sgn), .mag_o(d_mag),
      .nan_o(d_nan), .qnan_o(d_qnan));

    always_comb begin
      sgn[g]  = dbl_i ? d_sgn  : s_sgn;
      mag[g]  = dbl_i ? d_mag  : {{(MAG_W - S_MAG_W){1'b0}}, s_mag};
      nan[g]  = dbl_i ? d_nan  : s_nan;
      qnan[g] = dbl_i ? d_qnan : s_qnan;
    end
  end

  rel_t rel;
  logic eq_w, lt_w, hit, raise;

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .sign_a_i(sgn[0]), .mag_a_i(mag[0]),
    .sign_b_i(sgn[1]), .mag_b_i(mag[1]),
    .eq_o(eq_w), .lt_o(lt_w));

  always_comb begin
    rel.unord = nan[0] || nan[1];
    rel.eq    = eq_w;
    rel.lt    = lt_w;
  end

  fpcmp_predicate u_pred (
    .code_i(cond_i), .rel_i(rel),
    .any_nan_i(nan[0] || nan[1]), .any_qnan_i(qnan[0] || qnan[1]),
    .hit_o(hit), .raise_o(raise));

  logic trapped;
  assign trapped = raise && trap_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_flag_o  <= 1'b0;
      invalid_o    <= 1'b0;
      exc_req_o    <= 1'b0;
      inv_sticky_o <= 1'b0;
    end else begin
      invalid_o <= start_i && raise;
      exc_req_o <= start_i && trapped;
      if (start_i && !trapped)
        cond_flag_o <= hit;
      if (start_i && raise && !trap_en_i)
        inv_sticky_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fpcmp_cond_unit_chk.sv
module fpcmp_cond_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic trap_en_i,
  input logic cond_flag_o,
  input logic invalid_o,
  input logic exc_req_o,
  input logic inv_sticky_o
);
  p_exc_has_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> invalid_o);
  p_exc_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> ($stable(cond_flag_o) && $stable(inv_sticky_o)));
  p_exc_needs_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> ($past(trap_en_i) && $past(start_i)));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(cond_flag_o) && !invalid_o && !exc_req_o));
  p_sticky_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_sticky_o |=> inv_sticky_o);
  p_sticky_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_sticky_o) |-> (invalid_o && !exc_req_o));
endmodule

bind fpcmp_cond_unit fpcmp_cond_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .trap_en_i(trap_en_i),
  .cond_flag_o(cond_flag_o), .invalid_o(invalid_o),
  .exc_req_o(exc_req_o), .inv_sticky_o(inv_sticky_o));

// File: tb/fpcmp_cond_unit_tb_top.sv
module fpcmp_cond_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, dbl_i = 1'b0, trap_en_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [3:0] cond_i = '0;
  logic cond_flag_o, invalid_o, exc_req_o, inv_sticky_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpcmp_cond_unit dut_i (.*);

  localparam logic [63:0] S1 = 64'h3F800000, S2 = 64'h40000000, SM1 = 64'hBF800000,
    SM2 = 64'hC0000000, SPZ = 64'h0, SNZ = 64'h80000000, SQN = 64'h7FC00000,
    SSN = 64'h7F800001, SINF = 64'h7F800000,
    D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000, DM2 = 64'hC000000000000000,
    DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001, DNZ = 64'h8000000000000000;

  typedef struct packed {
    logic dbl; logic [63:0] a; logic [63:0] b; logic [3:0] code;
    logic eflag; logic einv;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, S1, S2, 4'd4, 1'b1, 1'b0},    // R2 R5 OLT true
    '{1'b0, S2, S1, 4'd4, 1'b0, 1'b0},    // R2 R5 OLT false
    '{1'b0, SM1, S1, 4'd12, 1'b1, 1'b0},  // R5 negative below positive
    '{1'b0, SPZ, SNZ, 4'd2, 1'b1, 1'b0},  // R5 zeros equal
    '{1'b0, SNZ, SPZ, 4'd4, 1'b0, 1'b0},  // R5 -0 not below +0
    '{1'b0, S1, S1, 4'd6, 1'b1, 1'b0},    // R2 OLE on equal
    '{1'b0, SQN, S1, 4'd1, 1'b1, 1'b1},   // R4 R6 quiet NaN low half
    '{1'b0, SSN, S1, 4'd1, 1'b1, 1'b0},   // R6 signalling NaN low half silent
    '{1'b0, SSN, S1, 4'd9, 1'b1, 1'b1},   // R6 signalling NaN high half
    '{1'b0, SQN, S1, 4'd2, 1'b0, 1'b1},   // R2 ordered EQ false on NaN
    '{1'b0, SQN, S1, 4'd3, 1'b1, 1'b1},   // R2 UEQ true on NaN
    '{1'b0, S1, S1, 4'd0, 1'b0, 1'b0},    // R3 code 0
    '{1'b0, S1, S1, 4'd8, 1'b0, 1'b0},    // R3 code 8
    '{1'b0, SINF, S1, 4'd7, 1'b0, 1'b0},  // R4 infinity ordered
    '{1'b1, DM2, D1, 4'd5, 1'b1, 1'b0},   // R10 double ULT
    '{1'b1, D2, D1, 4'd13, 1'b0, 1'b0},   // R10 double NGE false
    '{1'b1, DSN, D1, 4'd5, 1'b1, 1'b0},   // R6 double sNaN low half
    '{1'b1, DQN, D2, 4'd15, 1'b1, 1'b1},  // R6 double qNaN high half
    '{1'b1, D1, D1, 4'd10, 1'b1, 1'b0},   // R10 double SEQ
    '{1'b0, 64'hFFFFFFFF3F800000, 64'h1234567840000000, 4'd4, 1'b1, 1'b0}, // R10 upper ignored
    '{1'b0, SM2, SM1, 4'd4, 1'b1, 1'b0},  // R5 two negatives
    '{1'b1, DNZ, 64'h0, 4'd14, 1'b1, 1'b0}, // R5 double zeros LE
    '{1'b0, S1, S1, 4'd11, 1'b1, 1'b0}    // R2 NGL on equal
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic run(input logic dbl, input logic [63:0] a, input logic [63:0] b,
                     input logic [3:0] code, input logic trap);
    @(negedge clk);
    dbl_i = dbl; opa_i = a; opb_i = b; cond_i = code; trap_en_i = trap; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 flag", cond_flag_o, 1'b0);
    chk("R1 invalid", invalid_o, 1'b0);
    chk("R1 exc", exc_req_o, 1'b0);
    chk("R1 sticky", inv_sticky_o, 1'b0);
    rst_n = 1'b1;

    // set the flag to 1 so a held value is observable
    run(1'b0, S1, S2, 4'd4, 1'b1);
    chk("R8 ordered with trap on", cond_flag_o, 1'b1);
    chk("R8 no exc without NaN", exc_req_o, 1'b0);
    // trapped quiet NaN: computed result would be 0
    run(1'b0, SQN, S1, 4'd4, 1'b1);
    chk("R8 exc", exc_req_o, 1'b1);
    chk("R8 invalid", invalid_o, 1'b1);
    chk("R8 flag held", cond_flag_o, 1'b1);
    chk("R8 sticky held", inv_sticky_o, 1'b0);
    // same compare, trap disabled
    run(1'b0, SQN, S1, 4'd4, 1'b0);
    chk("R7 flag updated", cond_flag_o, 1'b0);
    chk("R7 invalid", invalid_o, 1'b1);
    chk("R7 no exc", exc_req_o, 1'b0);
    chk("R7 sticky", inv_sticky_o, 1'b1);
    // idle cycle with new inputs but no strobe
    opa_i = S1; opb_i = S2; cond_i = 4'd4; dbl_i = 1'b0;
    @(negedge clk);
    chk("R9 pulse ends", invalid_o, 1'b0);
    chk("R9 flag holds", cond_flag_o, 1'b0);
    // ordered compare, sticky stays
    run(1'b0, S1, S2, 4'd4, 1'b0);
    chk("R11 sticky stays", inv_sticky_o, 1'b1);
    chk("R9 result on strobe edge", cond_flag_o, 1'b1);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].dbl, VECS[i].a, VECS[i].b, VECS[i].code, 1'b0);
      chk($sformatf("R2 table %0d flag", i), cond_flag_o, VECS[i].eflag);
      chk($sformatf("R6 table %0d invalid", i), invalid_o, VECS[i].einv);
      chk($sformatf("R8 table %0d exc", i), exc_req_o, 1'b0);
    end

    // reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sticky cleared", inv_sticky_o, 1'b0);
    chk("R1 flag cleared", cond_flag_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule